// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Condition Codes

This block is the combinational datapath of an 8-bit processor core. It takes an operation code, two operands and the present condition-code register. It returns a result, the next condition-code value, and a write-enable that tells the register file whether to store the result. Byte operations use the low eight bits of each 16-bit operand input. Word operations use all sixteen bits. The word operations load, store and compare the 16-bit index-register pair.

The condition-code register uses a fixed layout. From bit 7 down to bit 0 it holds: overflow V, a constant 1, a constant 1, half-carry H, interrupt mask I, negative N, zero Z and carry C. The block never changes I. Each operation names the flags it updates, and every other flag passes through unchanged. Compare, bit-test and test-for-zero set flags only, and they hold write-enable low.

The block has no state. The operation code acts as the selector of a one-level decision: each code leads to a single output assignment in one `unique case`. Codes 13 to 15 fall to the default branch.

Top module: `cc_alu`

## Requirements
- R1: `ccr_out` bits 6 and 5 are always 1. Bit 3 (I) always equals `ccr_in` bit 3. Any flag an operation does not update equals its `ccr_in` bit. Layout from bit 7: V,1,1,H,I,N,Z,C.
- R2: ADD (op 0) gives `result` = a[7:0]+b[7:0]. ADC (op 1) also adds `ccr_in` C. C is the carry out of bit 7 and H is the carry from bit 3 into bit 4. `result[15:8]` is 0, and write-enable is 1.
- R3: For additions, V is 1 when both operands have the same sign and the result's sign differs from it. For subtractions and compares, V is 1 when the operands' signs differ and the result's sign differs from the minuend.
- R4: SUB (op 2) gives a[7:0]-b[7:0]. SBC (op 3) also subtracts `ccr_in` C. C is the borrow, H is left unchanged, N and Z come from the byte, and write-enable is 1.
- R5: CMP (op 4) sets V, N, Z and C exactly as SUB does, without a carry-in. `result` shows the difference and write-enable is 0.
- R6: AND (op 5), OR (op 6) and XOR (op 7) write the bitwise byte with write-enable 1. BIT (op 8) forms a AND b with write-enable 0. All four clear V, set N and Z from the byte, and keep H and C.
- R7: Byte load/transfer (op 9) gives `result` = {8'h00, b[7:0]}. It clears V, sets N and Z, and has write-enable 1.
- R8: Test-for-zero (op 10) compares a[7:0] with 0x00. `result` = {8'h00, a[7:0]}, V is cleared, N and Z come from that byte, H and C are kept, and write-enable is 0.
- R9: Word load/store (op 11) gives `result` = b[15:0]. N is bit 15, Z is 1 only when all 16 bits are 0, V is cleared, and write-enable is 1.
- R10: Word compare (op 12) forms a-b on 16 bits. C is the borrow, V follows R3 at bit 15, N is bit 15, Z covers all 16 bits, and write-enable is 0.
- R11: Unused codes 13 to 15 give `result` = 0 and write-enable 0. `ccr_out` equals `ccr_in` with bits 6 and 5 forced to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 to 12 defined) |
| opnd_a | input | 16 | First operand / minuend; low byte for byte ops |
| opnd_b | input | 16 | Second operand / source; low byte for byte ops |
| ccr_in | input | 8 | Present condition-code register |
| result | output | 16 | Computed value, zero-extended for byte ops |
| ccr_out | output | 8 | Next condition-code register |
| wr_en | output | 1 | High when the result is to be written back |

## Verification
The checker watches several rules continuously, for every input combination the bench applies. These are: the two constant-one bits and the untouched interrupt mask; that Z agrees with a zero result and N with the correct sign bit; that V is clear for logical, load and test operations; and that write-enable is low exactly for the flag-only codes. The numeric results cannot be seen from those rules alone. This covers carry and borrow out of bit 7 and bit 15, the half-carry, the signed-overflow cases, carry-in for ADC and SBC, and the preservation of H and C across logical operations. Only the bench's directed scenarios show these, because each one compares against hand-worked values.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_ORA  = 4'd6,
        OP_EOR  = 4'd7,
        OP_BIT  = 4'd8,
        OP_LDB  = 4'd9,
        OP_TST  = 4'd10,
        OP_LDW  = 4'd11,
        OP_CPW  = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND  = 2'd0,
        LG_OR   = 2'd1,
        LG_XOR  = 2'd2,
        LG_PASS = 2'd3
    } logic_sel_e;

    localparam int CC_C = 0;
    localparam int CC_Z = 1;
    localparam int CC_N = 2;
    localparam int CC_I = 3;
    localparam int CC_H = 4;
    localparam int CC_V = 7;

    typedef struct packed {
        logic v;
        logic h;
        logic n;
        logic z;
        logic c;
    } flag_set_t;

endpackage

// File: rtl/cc_alu_addsub.sv
module cc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cy,
    output logic         ov
);
    logic [W-1:0] b_eff;
    logic         c_eff;
    logic         c_raw;

    always_comb begin
        b_eff        = sub ? ~b : b;
        c_eff        = sub ? ~cin : cin;
        {c_raw, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        cy           = sub ? ~c_raw : c_raw;
        ov           = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/cc_alu_logic.sv
module cc_alu_logic #(
    parameter int W = 8
) (
    input  cc_alu_pkg::logic_sel_e sel,
    input  logic [W-1:0]           a,
    input  logic [W-1:0]           b,
    output logic [W-1:0]           y
);
    import cc_alu_pkg::*;

    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            LG_PASS: y = b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/cc_alu_ccr_pack.sv
module cc_alu_ccr_pack (
    input  logic [7:0]             ccr_in,
    input  cc_alu_pkg::flag_set_t  upd,
    input  cc_alu_pkg::flag_set_t  nf,
    output logic [7:0]             ccr_out
);
    import cc_alu_pkg::*;

    always_comb begin
        ccr_out[CC_V]  = upd.v ? nf.v : ccr_in[CC_V];
        ccr_out[6:5]   = ccr_in[6:5] | 2'b11;
        ccr_out[CC_H]  = upd.h ? nf.h : ccr_in[CC_H];
        ccr_out[CC_I]  = ccr_in[CC_I];
        ccr_out[CC_N]  = upd.n ? nf.n : ccr_in[CC_N];
        ccr_out[CC_Z]  = upd.z ? nf.z : ccr_in[CC_Z];
        ccr_out[CC_C]  = upd.c ? nf.c : ccr_in[CC_C];
    end
endmodule

// File: rtl/cc_alu.sv
module cc_alu #(
    parameter int DW = 8
) (
    input  logic [3:0]      op_sel,
    input  logic [2*DW-1:0] opnd_a,
    input  logic [2*DW-1:0] opnd_b,
    input  logic [7:0]      ccr_in,
    output logic [2*DW-1:0] result,
    output logic [7:0]      ccr_out,
    output logic            wr_en
);
    import cc_alu_pkg::*;

    localparam int WW = 2 * DW;
    localparam int HB = DW / 2;

    alu_op_e    op;
    logic_sel_e lsel;
    logic       b_cin;
    logic       b_sub;

    logic [DW-1:0] a_lo;
    logic [DW-1:0] b_lo;
    logic [DW-1:0] bsum;
    logic          bcy;
    logic          bov;
    logic [WW-1:0] wsum;
    logic          wcy;
    logic          wov;
    logic [DW-1:0] ly;
    logic [HB:0]   nib;

    flag_set_t upd;
    flag_set_t nf;

    assign op   = alu_op_e'(op_sel);
    assign a_lo = opnd_a[DW-1:0];
    assign b_lo = opnd_b[DW-1:0];

    // operation decode into datapath controls
    always_comb begin
        b_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
        b_cin = ((op == OP_ADC) || (op == OP_SBC)) && ccr_in[CC_C];
        unique case (op)
            OP_ORA:  lsel = LG_OR;
            OP_EOR:  lsel = LG_XOR;
            OP_LDB:  lsel = LG_PASS;
            default: lsel = LG_AND;
        endcase
        nib = {1'b0, a_lo[HB-1:0]} + {1'b0, b_lo[HB-1:0]} + {{HB{1'b0}}, b_cin};
    end

    cc_alu_addsub #(.W(DW)) u_byte (
        .a   (a_lo),
        .b   (b_lo),
        .cin (b_cin),
        .sub (b_sub),
        .sum (bsum),
        .cy  (bcy),
        .ov  (bov)
    );

    cc_alu_addsub #(.W(WW)) u_word (
        .a   (opnd_a),
        .b   (opnd_b),
        .cin (1'b0),
        .sub (1'b1),
        .sum (wsum),
        .cy  (wcy),
        .ov  (wov)
    );

    cc_alu_logic #(.W(DW)) u_logic (
        .sel (lsel),
        .a   (a_lo),
        .b   (b_lo),
        .y   (ly)
    );

    // per-operation result, write-enable and flag selection
    always_comb begin
        result = '0;
        wr_en  = 1'b0;
        upd    = '0;
        nf     = '0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                result = {{DW{1'b0}}, bsum};
                wr_en  = 1'b1;
                upd    = '{v: 1'b1, h: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
                nf     = '{v: bov, h: nib[HB], n: bsum[DW-1], z: ~|bsum, c: bcy};
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                result = {{DW{1'b0}}, bsum};
                wr_en  = (op != OP_CMP);
                upd    = '{v: 1'b1, h: 1'b0, n: 1'b1, z: 1'b1, c: 1'b1};
                nf     = '{v: bov, h: 1'b0, n: bsum[DW-1], z: ~|bsum, c: bcy};
            end
            OP_AND, OP_ORA, OP_EOR, OP_BIT, OP_LDB: begin
                result = {{DW{1'b0}}, ly};
                wr_en  = (op != OP_BIT);
                upd    = '{v: 1'b1, h: 1'b0, n: 1'b1, z: 1'b1, c: 1'b0};
                nf     = '{v: 1'b0, h: 1'b0, n: ly[DW-1], z: ~|ly, c: 1'b0};
            end
            OP_TST: begin
                result = {{DW{1'b0}}, a_lo};
                wr_en  = 1'b0;
                upd    = '{v: 1'b1, h: 1'b0, n: 1'b1, z: 1'b1, c: 1'b0};
                nf     = '{v: 1'b0, h: 1'b0, n: a_lo[DW-1], z: ~|a_lo, c: 1'b0};
            end
            OP_LDW: begin
                result = opnd_b;
                wr_en  = 1'b1;
                upd    = '{v: 1'b1, h: 1'b0, n: 1'b1, z: 1'b1, c: 1'b0};
                nf     = '{v: 1'b0, h: 1'b0, n: opnd_b[WW-1], z: ~|opnd_b, c: 1'b0};
            end
            OP_CPW: begin
                result = wsum;
                wr_en  = 1'b0;
                upd    = '{v: 1'b1, h: 1'b0, n: 1'b1, z: 1'b1, c: 1'b1};
                nf     = '{v: wov, h: 1'b0, n: wsum[WW-1], z: ~|wsum, c: wcy};
            end
            default: begin
                result = '0;
                wr_en  = 1'b0;
            end
        endcase
    end

    cc_alu_ccr_pack u_pack (
        .ccr_in  (ccr_in),
        .upd     (upd),
        .nf      (nf),
        .ccr_out (ccr_out)
    );
endmodule

// File: rtl/cc_alu_checker.sv
module cc_alu_checker #(
    parameter int DW = 8
) (
    input logic [3:0]      op_sel,
    input logic [2*DW-1:0] opnd_a,
    input logic [2*DW-1:0] opnd_b,
    input logic [7:0]      ccr_in,
    input logic [2*DW-1:0] result,
    input logic [7:0]      ccr_out,
    input logic            wr_en
);
    localparam int WW = 2 * DW;

    logic valid_op;
    logic word_op;
    logic flag_only;
    logic v_cleared;

    always_comb begin
        valid_op  = (op_sel <= 4'd12);
        word_op   = (op_sel == 4'd11) || (op_sel == 4'd12);
        flag_only = (op_sel == 4'd4) || (op_sel == 4'd8) || (op_sel == 4'd10) ||
                    (op_sel == 4'd12) || !valid_op;
        v_cleared = (op_sel >= 4'd5) && (op_sel <= 4'd11);

        // R1: constant-one bits
        p_fixed_ones_r1: assert (ccr_out[6:5] == 2'b11)
            else $error("ccr bits 6:5 not one");
        // R1: interrupt mask never altered
        p_imask_kept_r1: assert (ccr_out[3] == ccr_in[3])
            else $error("interrupt mask changed");
        // R5 R6 R8 R10 R11: flag-only codes never write
        p_write_gate_r5: assert (wr_en == !flag_only)
            else $error("write-enable wrong for op %0d", op_sel);
        // R6 R7 R8 R9: V cleared
        p_v_clear_r6: assert (!v_cleared || !ccr_out[7])
            else $error("V not cleared for op %0d", op_sel);
        // R9 R10: Z spans the whole result
        p_zero_whole_r9: assert (!valid_op || (ccr_out[1] == (result == '0)))
            else $error("Z disagrees with result");
        // R10: N from the correct sign bit
        p_sign_bit_r10: assert (!valid_op ||
                                (ccr_out[2] == (word_op ? result[WW-1] : result[DW-1])))
            else $error("N disagrees with sign bit");
        // R9: word load passes the source
        p_word_pass_r9: assert (op_sel != 4'd11 || result == opnd_b)
            else $error("word load result wrong");
        // R8: test-for-zero reflects operand a
        p_tst_pass_r8: assert (op_sel != 4'd10 || result == {{DW{1'b0}}, opnd_a[DW-1:0]})
            else $error("test result wrong");
        // R11: unused codes leave flags and give zero
        p_unused_r11: assert (valid_op || (result == '0 && ccr_out == (ccr_in | 8'h60)))
            else $error("unused code altered state");
    end
endmodule

bind cc_alu cc_alu_checker #(.DW(DW)) u_chk (
    .op_sel  (op_sel),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .ccr_in  (ccr_in),
    .result  (result),
    .ccr_out (ccr_out),
    .wr_en   (wr_en)
);

// File: tb/cc_alu_test.sv
module cc_alu_test;
    logic        clk = 1'b0;
    logic [3:0]  op_sel;
    logic [15:0] opnd_a;
    logic [15:0] opnd_b;
    logic [7:0]  ccr_in;
    logic [15:0] result;
    logic [7:0]  ccr_out;
    logic        wr_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cc_alu uut (
        .op_sel  (op_sel),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .ccr_in  (ccr_in),
        .result  (result),
        .ccr_out (ccr_out),
        .wr_en   (wr_en)
    );

    task automatic apply(input logic [3:0] op, input logic [15:0] a,
                         input logic [15:0] b, input logic [7:0] cc);
        @(negedge clk);
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        ccr_in = cc;
        #2;
    endtask

    task automatic expect3(input string tag, input logic [15:0] r_exp,
                           input logic [7:0] c_exp, input logic w_exp);
        checks++;
        if (result !== r_exp || ccr_out !== c_exp || wr_en !== w_exp) begin
            errors++;
            $display("FAIL %s: result=%h ccr=%h wr=%b, expected result=%h ccr=%h wr=%b",
                     tag, result, ccr_out, wr_en, r_exp, c_exp, w_exp);
        end
    endtask

    task automatic t_idle();
        apply(4'd0, 16'h0000, 16'h0000, 8'h00);
        expect3("R1 idle zero add", 16'h0000, 8'h62, 1'b1);
    endtask

    task automatic t_add();
        apply(4'd0, 16'hEE3A, 16'h7748, 8'h00);
        expect3("R2 R3 add half-carry overflow", 16'h0082, 8'hF4, 1'b1);
        apply(4'd0, 16'h00FF, 16'h0001, 8'h08);
        expect3("R2 add carry out, I kept", 16'h0000, 8'h7B, 1'b1);
        apply(4'd1, 16'h0010, 16'h0020, 8'h01);
        expect3("R2 adc carry-in", 16'h0031, 8'h60, 1'b1);
    endtask

    task automatic t_sub();
        apply(4'd2, 16'h0050, 16'h0070, 8'h10);
        expect3("R4 sub borrow H kept", 16'h00E0, 8'h75, 1'b1);
        apply(4'd2, 16'h0080, 16'h0001, 8'h00);
        expect3("R3 sub overflow", 16'h007F, 8'hE0, 1'b1);
        apply(4'd3, 16'h0005, 16'h0005, 8'h01);
        expect3("R4 sbc borrow-in", 16'h00FF, 8'h65, 1'b1);
    endtask

    task automatic t_cmp();
        apply(4'd4, 16'h0042, 16'h0042, 8'h09);
        expect3("R5 cmp equal no write", 16'h0000, 8'h6A, 1'b0);
    endtask

    task automatic t_logic();
        apply(4'd5, 16'h00F0, 16'h000F, 8'h93);
        expect3("R6 and zero keeps H C", 16'h0000, 8'h73, 1'b1);
        apply(4'd6, 16'h0081, 16'h0002, 8'h80);
        expect3("R6 or clears V", 16'h0083, 8'h64, 1'b1);
        apply(4'd7, 16'h00AA, 16'h00AA, 8'h01);
        expect3("R6 xor to zero", 16'h0000, 8'h63, 1'b1);
        apply(4'd8, 16'h0080, 16'h00C0, 8'h00);
        expect3("R6 bit test no write", 16'h0080, 8'h64, 1'b0);
    endtask

    task automatic t_load();
        apply(4'd9, 16'h00FF, 16'hAB00, 8'h85);
        expect3("R7 byte load zero", 16'h0000, 8'h63, 1'b1);
        apply(4'd11, 16'h0000, 16'h8000, 8'h02);
        expect3("R9 word load negative", 16'h8000, 8'h64, 1'b1);
        apply(4'd11, 16'h0000, 16'h0100, 8'h00);
        expect3("R9 word load low byte zero", 16'h0100, 8'h60, 1'b1);
    endtask

    task automatic t_tst();
        apply(4'd10, 16'h009C, 16'h0000, 8'h13);
        expect3("R8 tst negative", 16'h009C, 8'h75, 1'b0);
        apply(4'd10, 16'h5500, 16'h00FF, 8'h80);
        expect3("R8 tst zero", 16'h0000, 8'h62, 1'b0);
    endtask

    task automatic t_cpw();
        apply(4'd12, 16'h1234, 16'h1235, 8'h00);
        expect3("R10 word cmp borrow", 16'hFFFF, 8'h65, 1'b0);
        apply(4'd12, 16'h0100, 16'h0100, 8'h00);
        expect3("R10 word cmp equal", 16'h0000, 8'h62, 1'b0);
        apply(4'd12, 16'h8000, 16'h0001, 8'h00);
        expect3("R10 R3 word cmp overflow", 16'h7FFF, 8'hE0, 1'b0);
        apply(4'd12, 16'h0200, 16'h0100, 8'h00);
        expect3("R10 word cmp low byte zero", 16'h0100, 8'h60, 1'b0);
    endtask

    task automatic t_unused();
        apply(4'd13, 16'h1234, 16'h5678, 8'h1F);
        expect3("R11 unused code", 16'h0000, 8'h7F, 1'b0);
        apply(4'd15, 16'hFFFF, 16'hFFFF, 8'h80);
        expect3("R11 unused code top", 16'h0000, 8'hE0, 1'b0);
    endtask

    initial begin
        op_sel = 4'd0;
        opnd_a = '0;
        opnd_b = '0;
        ccr_in = '0;
        repeat (2) @(posedge clk);
        t_idle();
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_load();
        t_tst();
        t_cpw();
        t_unused();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule